// File: doc/BRIEF.md
# Command-Only Read Chunk Sequencer

This block takes a read command that reaches the memory controller without any data flits. It breaks the requested byte count into burst-sized chunks and hands one chunk at a time to the shared per-channel scheduler. The chunks are spread evenly over a drain period, which models the rate at which data arrives over the slowest link. The scheduler is the same one the flit path uses, so both paths update one copy of channel availability and last direction. The scheduler sits outside this block.

A command is accepted with a one-cycle `start` pulse. The block first waits out a header-decode overhead, which is applied once. It then issues the chunks. Chunk `i` is addressed at the base address plus `i` burst lengths. When it issues a chunk, the block samples the scheduler's reply, which gives the cycles until that chunk finishes. After the last chunk it waits for the latest finish and then pulses `seq_done`.

The controller has four states:
- `ST_IDLE` waits for a command. `start` moves it to `ST_HDR`.
- `ST_HDR` counts the overhead. When the count expires it moves to `ST_PACE`, or to `ST_DRAIN` if the command has no chunks.
- `ST_PACE` counts one interval and issues a chunk at the end of it. It stays in `ST_PACE` for the next chunk, or moves to `ST_DRAIN` after the last one.
- `ST_DRAIN` waits until the latest finish time has passed. It then pulses `seq_done` and returns to `ST_IDLE`.

Top module: `rdcmd_chunk_seq`

## Requirements
- R1: The work size is `cmd_bytes` when that is non-zero, otherwise `req_bytes`.
- R2: The chunk count is n = ceil(work / 2^BURST_LOG2). It is 0 when the work size is 0.
- R3: Chunk i carries `chunk_addr` = (`base_addr` + i·2^BURST_LOG2) mod 2^ADDR_W.
- R4: Cycle 0 is the first cycle after the edge that accepts `start`. Let H = `hdr_cycles`, q = floor(`drain_cycles`/n) and r = `drain_cycles` mod n. Chunk i has gap g_i = q, except the last chunk, whose gap is q + r. Any gap of 0 counts as 1. Chunk i is issued in cycle T_i = H + g_0 + … + g_i.
- R5: A command with zero chunks issues no chunk and pulses `seq_done` in cycle H+1.
- R6: Each chunk's finish is F_i = T_i + `chunk_lat`, with `chunk_lat` sampled in that chunk's issue cycle. `seq_done` is a one-cycle pulse in cycle max(T_last+1, max F_i).
- R7: A `start` pulse that arrives while a command is in progress is ignored. The ongoing schedule, addresses and completion do not change.
- R8: After reset, `chunk_vld` and `seq_done` are low and the block is idle.
- R9: `chunk_vld` is high for exactly n single cycles per command, and never in the same cycle as `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept a command (ignored when busy) |
| cmd_bytes | input | BYTES_W | Byte count carried by the command |
| req_bytes | input | BYTES_W | Byte count of the underlying request |
| base_addr | input | ADDR_W | Byte address of the first chunk |
| drain_cycles | input | DRAIN_W | Drain period spread across the chunks |
| hdr_cycles | input | HDR_W | Header-decode overhead in cycles |
| chunk_vld | output | 1 | A chunk is issued to the scheduler this cycle |
| chunk_addr | output | ADDR_W | Address of the issued chunk |
| chunk_lat | input | LAT_W | Scheduler reply: cycles from issue to finish |
| seq_done | output | 1 | Completion pulse |

## Verification
The sweep covers several groups of corner cases:
- Commands whose own byte count is zero, so the request size must be used. A design that picks the wrong source issues too many or too few chunks.
- Drain periods smaller than the chunk count, which give zero intervals, and periods that leave a remainder. A design that drops the minimum-one rule issues two chunks in one cycle. A design that drops the remainder finishes the chunk train early.
- Scheduler replies that reach past the last issue. Completing on the last chunk's finish instead of the maximum finish pulses `seq_done` too early.
- Base addresses near the top of the address space, so the chunk address wraps.
- Stray `start` pulses mid-command. A design that accepts them restarts the schedule.

// File: rtl/rdcmd_pkg.sv
package rdcmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PACE,
        ST_DRAIN
    } seq_state_t;

endpackage

// File: rtl/rdcmd_plan.sv
// Turns a command into a chunk count, a base interval and a remainder.
module rdcmd_plan #(
    parameter int BYTES_W    = 16,
    parameter int BURST_LOG2 = 8,
    parameter int DRAIN_W    = 16,
    parameter int CNT_W      = BYTES_W - BURST_LOG2 + 1
) (
    input  logic [BYTES_W-1:0] cmd_bytes,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic [DRAIN_W-1:0] drain_cycles,
    output logic [CNT_W-1:0]   n_chunks,
    output logic [DRAIN_W-1:0] interval,
    output logic [DRAIN_W-1:0] remainder
);
    localparam int DW = (DRAIN_W > CNT_W) ? DRAIN_W : CNT_W;
    localparam logic [BYTES_W:0] ROUND = (BYTES_W+1)'((1 << BURST_LOG2) - 1);

    logic [BYTES_W-1:0] work;
    logic [BYTES_W:0]   padded;
    logic [DW-1:0]      num, den;

    always_comb begin
        work     = (cmd_bytes != '0) ? cmd_bytes : req_bytes;
        padded   = {1'b0, work} + ROUND;
        n_chunks = CNT_W'(padded >> BURST_LOG2);
        num      = DW'(drain_cycles);
        den      = DW'(n_chunks);
        if (n_chunks == '0) begin
            interval  = '0;
            remainder = '0;
        end else begin
            interval  = DRAIN_W'(num / den);
            remainder = DRAIN_W'(num % den);
        end
    end

endmodule

// File: rtl/rdcmd_addr_step.sv
// Holds the current chunk address and steps it by one burst per issue.
module rdcmd_addr_step #(
    parameter int ADDR_W     = 37,
    parameter int BURST_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << BURST_LOG2;

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= base;
        end else if (advance) begin
            addr_q <= addr_q + STEP;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/rdcmd_finish_track.sv
// Cycles left until the latest issued chunk finishes (saturating at zero).
module rdcmd_finish_track #(
    parameter int LAT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             issue,
    input  logic [LAT_W-1:0] lat,
    output logic             pend_zero
);
    logic [LAT_W-1:0] pend_q, dec, cand, pend_d;

    always_comb begin
        dec  = (pend_q == '0) ? '0 : pend_q - LAT_W'(1);
        cand = (lat == '0) ? '0 : lat - LAT_W'(1);
        if (clear) begin
            pend_d = '0;
        end else if (issue) begin
            pend_d = (cand > dec) ? cand : dec;
        end else begin
            pend_d = dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_zero = (pend_q == '0);

endmodule

// File: rtl/rdcmd_chunk_seq.sv
module rdcmd_chunk_seq
    import rdcmd_pkg::*;
#(
    parameter int ADDR_W     = 37,
    parameter int BYTES_W    = 16,
    parameter int BURST_LOG2 = 8,
    parameter int DRAIN_W    = 16,
    parameter int HDR_W      = 8,
    parameter int LAT_W      = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BYTES_W-1:0] cmd_bytes,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [DRAIN_W-1:0] drain_cycles,
    input  logic [HDR_W-1:0]   hdr_cycles,
    output logic               chunk_vld,
    output logic [ADDR_W-1:0]  chunk_addr,
    input  logic [LAT_W-1:0]   chunk_lat,
    output logic               seq_done
);
    localparam int CNT_W = BYTES_W - BURST_LOG2 + 1;
    localparam int CW    = (HDR_W > DRAIN_W) ? HDR_W : DRAIN_W;

    seq_state_t state_q, state_d;

    logic [CW-1:0]      cnt_q, cnt_d;
    logic [CNT_W-1:0]   idx_q, idx_d;
    logic [CNT_W-1:0]   n_q;
    logic [DRAIN_W-1:0] iv_q, rem_q;

    logic [CNT_W-1:0]   plan_n;
    logic [DRAIN_W-1:0] plan_iv, plan_rem;
    logic               accept, fire, last_chunk, pend_zero;
    logic [DRAIN_W-1:0] gap_first, gap_next;

    rdcmd_plan #(
        .BYTES_W   (BYTES_W),
        .BURST_LOG2(BURST_LOG2),
        .DRAIN_W   (DRAIN_W),
        .CNT_W     (CNT_W)
    ) plan_i (
        .cmd_bytes   (cmd_bytes),
        .req_bytes   (req_bytes),
        .drain_cycles(drain_cycles),
        .n_chunks    (plan_n),
        .interval    (plan_iv),
        .remainder   (plan_rem)
    );

    rdcmd_addr_step #(
        .ADDR_W    (ADDR_W),
        .BURST_LOG2(BURST_LOG2)
    ) addr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .base   (base_addr),
        .advance(fire),
        .addr   (chunk_addr)
    );

    rdcmd_finish_track #(
        .LAT_W(LAT_W)
    ) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .issue    (fire),
        .lat      (chunk_lat),
        .pend_zero(pend_zero)
    );

    always_comb begin
        accept     = (state_q == ST_IDLE) && start;
        fire       = (state_q == ST_PACE) && (cnt_q <= CW'(1));
        last_chunk = (idx_q == n_q - CNT_W'(1));
        gap_first  = iv_q + ((n_q == CNT_W'(1)) ? rem_q : '0);
        gap_next   = iv_q + (((idx_q + CNT_W'(1)) == (n_q - CNT_W'(1))) ? rem_q : '0);
    end

    // next state and counters
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_HDR;
                    cnt_d   = CW'(hdr_cycles);
                    idx_d   = '0;
                end
            end
            ST_HDR: begin
                if (cnt_q == '0) begin
                    if (n_q == '0) begin
                        state_d = ST_DRAIN;
                    end else begin
                        state_d = ST_PACE;
                        cnt_d   = CW'(gap_first);
                    end
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            ST_PACE: begin
                if (fire) begin
                    if (last_chunk) begin
                        state_d = ST_DRAIN;
                    end else begin
                        cnt_d = CW'(gap_next);
                        idx_d = idx_q + CNT_W'(1);
                    end
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            ST_DRAIN: begin
                if (pend_zero) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

    // command plan, latched on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q   <= '0;
            iv_q  <= '0;
            rem_q <= '0;
        end else if (accept) begin
            n_q   <= plan_n;
            iv_q  <= plan_iv;
            rem_q <= plan_rem;
        end
    end

    // outputs
    always_comb begin
        chunk_vld = fire;
        seq_done  = (state_q == ST_DRAIN) && pend_zero;
    end

endmodule

// File: rtl/rdcmd_chunk_seq_chk.sv
module rdcmd_chunk_seq_chk #(
    parameter int ADDR_W     = 37,
    parameter int BURST_LOG2 = 8,
    parameter int LAT_W      = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chunk_vld,
    input logic [ADDR_W-1:0] chunk_addr,
    input logic [LAT_W-1:0]  chunk_lat,
    input logic              seq_done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << BURST_LOG2;

    logic              seen_q;
    logic [ADDR_W-1:0] prev_q;
    logic [LAT_W-1:0]  left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            prev_q <= '0;
            left_q <= '0;
        end else if (seq_done) begin
            seen_q <= 1'b0;
            left_q <= '0;
        end else begin
            if (chunk_vld) begin
                seen_q <= 1'b1;
                prev_q <= chunk_addr;
            end
            if (chunk_vld && (chunk_lat > LAT_W'(1)) && (chunk_lat - LAT_W'(1) > left_q)) begin
                left_q <= chunk_lat - LAT_W'(1);
            end else if (left_q != '0) begin
                left_q <= left_q - LAT_W'(1);
            end
        end
    end

    // R3: consecutive chunks of one command step by one burst
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_vld && seen_q) |-> (chunk_addr == prev_q + STEP));

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    // R6: completion only after every issued chunk has finished
    p_finish_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (left_q == '0));

    // R9: no chunk issue in the completion cycle
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(chunk_vld && seq_done));

endmodule

bind rdcmd_chunk_seq rdcmd_chunk_seq_chk #(
    .ADDR_W    (ADDR_W),
    .BURST_LOG2(BURST_LOG2),
    .LAT_W     (LAT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .chunk_vld (chunk_vld),
    .chunk_addr(chunk_addr),
    .chunk_lat (chunk_lat),
    .seq_done  (seq_done)
);

// File: tb/rdcmd_chunk_seq_tb_top.sv
`timescale 1ns/1ps
module rdcmd_chunk_seq_tb_top;
    localparam int ADDR_W     = 12;
    localparam int BYTES_W    = 6;
    localparam int BURST_LOG2 = 2;
    localparam int DRAIN_W    = 6;
    localparam int HDR_W      = 3;
    localparam int LAT_W      = 4;
    localparam int BURST      = 1 << BURST_LOG2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [BYTES_W-1:0] cmd_bytes = '0;
    logic [BYTES_W-1:0] req_bytes = '0;
    logic [ADDR_W-1:0]  base_addr = '0;
    logic [DRAIN_W-1:0] drain_cycles = '0;
    logic [HDR_W-1:0]   hdr_cycles = '0;
    logic               chunk_vld;
    logic [ADDR_W-1:0]  chunk_addr;
    logic [LAT_W-1:0]   chunk_lat;
    logic               seq_done;

    int errors = 0;
    int checks = 0;
    int gcyc   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic int lat_of(int a);
        return (((a >> BURST_LOG2) * 3) + 1) % 7;
    endfunction

    assign chunk_lat = LAT_W'(lat_of(int'(chunk_addr)));

    rdcmd_chunk_seq #(
        .ADDR_W(ADDR_W), .BYTES_W(BYTES_W), .BURST_LOG2(BURST_LOG2),
        .DRAIN_W(DRAIN_W), .HDR_W(HDR_W), .LAT_W(LAT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_bytes(cmd_bytes), .req_bytes(req_bytes), .base_addr(base_addr),
        .drain_cycles(drain_cycles), .hdr_cycles(hdr_cycles),
        .chunk_vld(chunk_vld), .chunk_addr(chunk_addr), .chunk_lat(chunk_lat),
        .seq_done(seq_done)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cmd(int cb, int rb, int base, int dr, int hd, bit noise);
        int work, n, q, r, t, g, maxf, dexp;
        int et[32];
        int ea[32];
        int at[32];
        int aa[32];
        int got, dcyc, cyc;
        work = (cb != 0) ? cb : rb;
        n    = (work + BURST - 1) / BURST;
        q    = (n != 0) ? dr / n : 0;
        r    = (n != 0) ? dr % n : 0;
        t    = hd;
        maxf = 0;
        for (int i = 0; i < n; i++) begin
            g = q + ((i == n - 1) ? r : 0);
            if (g < 1) g = 1;
            t += g;
            et[i] = t;
            ea[i] = (base + i * BURST) % (1 << ADDR_W);
            if (t + lat_of(ea[i]) > maxf) maxf = t + lat_of(ea[i]);
        end
        if (n == 0) dexp = hd + 1;
        else dexp = (et[n-1] + 1 > maxf) ? et[n-1] + 1 : maxf;

        @(negedge clk);
        start        = 1'b1;
        cmd_bytes    = BYTES_W'(cb);
        req_bytes    = BYTES_W'(rb);
        base_addr    = ADDR_W'(base);
        drain_cycles = DRAIN_W'(dr);
        hdr_cycles   = HDR_W'(hd);
        @(negedge clk);
        start = 1'b0;
        got  = 0;
        dcyc = -1;
        cyc  = 0;
        while (cyc < 300) begin
            if (noise && cyc == 1) begin
                start        = 1'b1;
                cmd_bytes    = BYTES_W'(cb + 9);
                base_addr    = ADDR_W'(base + 64);
                drain_cycles = DRAIN_W'(dr + 3);
                hdr_cycles   = HDR_W'(hd + 2);
            end else begin
                start = 1'b0;
            end
            if (chunk_vld && got < 32) begin
                at[got] = cyc;
                aa[got] = int'(chunk_addr);
                got++;
            end
            if (seq_done) begin
                dcyc = cyc;
                break;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        // R1 when the request size is the source, R2 otherwise; R9 pulse count
        if (cb == 0 && rb != 0) check(got == n, "R1 chunk count", got, n);
        else check(got == n, "R2 chunk count", got, n);
        for (int i = 0; i < n && i < got; i++) begin
            check(at[i] == et[i], noise ? "R7 chunk cycle" : "R4 chunk cycle", at[i], et[i]);
            check(aa[i] == ea[i], "R3 chunk address", aa[i], ea[i]);
        end
        if (n == 0) check(dcyc == dexp, "R5 done cycle", dcyc, dexp);
        else check(dcyc == dexp, noise ? "R7 done cycle" : "R6 done cycle", dcyc, dexp);
    endtask

    initial begin : watchdog
        while (gcyc < 150000 && !finished) begin
            @(posedge clk);
            gcyc++;
        end
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", gcyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int cmds[8] = '{0, 1, 3, 4, 5, 8, 9, 17};
        int reqs[5] = '{0, 2, 4, 7, 13};
        int drs[7]  = '{0, 1, 2, 3, 5, 9, 14};
        int k;
        repeat (3) @(negedge clk);
        // R8: idle outputs under reset and after release
        check(chunk_vld == 1'b0, "R8 chunk_vld in reset", int'(chunk_vld), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(chunk_vld == 1'b0, "R8 chunk_vld idle", int'(chunk_vld), 0);
        check(seq_done == 1'b0, "R8 seq_done idle", int'(seq_done), 0);

        k = 0;
        for (int h = 0; h < 3; h++) begin
            for (int c = 0; c < 8; c++) begin
                for (int q = 0; q < 5; q++) begin
                    for (int d = 0; d < 7; d++) begin
                        run_cmd(cmds[c], reqs[q], (k % 2 == 0) ? 'h100 : 'hFF8,
                                drs[d], (h == 2) ? 3 : h, (k % 5 == 3));
                        k++;
                    end
                end
            end
        end
        // R3 wrap at the top of the address space with many chunks
        run_cmd(40, 0, 'hFFC, 21, 0, 1'b0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule